// File: doc/BRIEF.md
# External Data Memory Access Controller

This block sits between a simple CPU load/store request port and two data memories. It decodes every 16-bit data-space address. Addresses below the internal limit (8,448 locations by default: registers, I/O, extended I/O and internal SRAM) go to an internal memory port and complete in the same cycle. Every address from that limit up to the top of the 64K space goes to an external asynchronous SRAM bus. The bus carries the address, write data and read data, plus separate active-low read and write strobes.

An external access stretches the CPU with a stall output. The stall lasts one extra cycle with zero wait states. It lasts two, three or four extra cycles with one, two or three wait states. The wait-state count and an external-enable bit come in as inputs from a control register. When the enable is clear, an access to the external region still completes in internal timing. A read then returns zero, a write is discarded, and no strobe moves. The requester holds its request steady while stall is high. Multi-byte sequences such as stack pushes are issued by the requester one byte at a time.

Top module: `xmem_access_ctrl`

## Requirements
- R1: A valid request with address below 0x2100 (8448) asserts `int_sel` in the same cycle, never asserts `cpu_stall`, and keeps both `ext_rd_n` and `ext_wr_n` high.
- R2: With `cfg_ext_en`=1, a valid request with address 0x2100 or above holds `cpu_stall` high for exactly `cfg_wait`+1 consecutive cycles (1, 2, 3, 4 for `cfg_wait` 0, 1, 2, 3), and the access completes in the first cycle with `cpu_stall` low.
- R3: Both strobes are active low and never low together. `ext_rd_n` is low in every stall cycle of an external read, and `ext_wr_n` is low in every stall cycle of an external write. Both are high outside the stall cycles and after reset.
- R4: `ext_addr` and `ext_wdata` are stable for every stall cycle of an external access and equal the requested address and write data.
- R5: For an external read, the value on `ext_rdata` in the last stall cycle appears on `rsp_rdata` in the completing cycle.
- R6: With `cfg_ext_en`=0, an access to the external region has no stall and no strobe, and `int_sel` and `int_write` stay low. A read returns 0x00 on `rsp_rdata`, and a write is dropped.
- R7: An internal read returns `int_rdata` on `rsp_rdata` in the same cycle. An internal write asserts `int_write` with `int_wdata` equal to the request data.
- R8: The wait-state count is taken when an external access starts. A change of `cfg_wait` during the stall does not change that access's length.
- R9: Address 0x20FF is internal; addresses 0x2100 and 0xFFFF are external.
- R10: External requests issued back to back, with no idle cycle between them, are each stretched by their own full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU access request, held while stalled |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 8 | Store data |
| rsp_rdata | output | 8 | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | Holds the CPU during external stretch cycles |
| cfg_ext_en | input | 1 | External memory enable |
| cfg_wait | input | 2 | Wait-state count 0..3 |
| int_sel | output | 1 | Internal memory select |
| int_write | output | 1 | Internal memory write enable |
| int_addr | output | 16 | Internal memory address |
| int_wdata | output | 8 | Internal memory write data |
| int_rdata | input | 8 | Internal memory read data (combinational) |
| ext_addr | output | 16 | External SRAM address |
| ext_wdata | output | 8 | External SRAM write data |
| ext_rdata | input | 8 | External SRAM read data |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The bench probes the region boundary at 0x20FF, 0x2100 and 0xFFFF. A comparator that is off by one would stall on the last internal location or send the first external one to the internal port. Every wait-state setting is run and its stall cycles are counted. A counter that loads the count minus one, or that rereads `cfg_wait` mid-access (the bench changes it during the stall), gives the wrong length. The SRAM model drives garbage whenever the read strobe is high. A design that samples read data late, or that drops the strobe before its last stall cycle, therefore returns the wrong byte. The tests also cover disabled-region accesses, which must return zero and leave the strobes and the internal write idle, and back-to-back external accesses, which catch a sequencer that does not rearm.

// File: rtl/xmem_pkg.sv
// Package: shared types for the external data memory access controller.
// Assumes a single clock domain; holds no logic beyond type definitions.
package xmem_pkg;

    // Routing result of one decoded request
    typedef enum logic [1:0] {
        RG_IDLE = 2'd0,   // no request this cycle
        RG_INT  = 2'd1,   // internal memory port
        RG_EXT  = 2'd2,   // external SRAM bus, enabled
        RG_OFF  = 2'd3    // external region while external memory is disabled
    } region_e;

endpackage

// File: rtl/xmem_decode.sv
// Module: xmem_decode
// Classifies a request address as internal, external or disabled-external.
// Assumes the internal region is the contiguous range [0, INT_TOP).
module xmem_decode
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INT_TOP = 8448
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ext_en,
    output region_e           region
);

    localparam logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(INT_TOP);

    // Purpose: pick the region for the current request
    always_comb begin
        if (!req_valid) begin
            region = RG_IDLE;
        end else if (req_addr < EXT_BASE) begin
            region = RG_INT;
        end else if (ext_en) begin
            region = RG_EXT;
        end else begin
            region = RG_OFF;
        end
    end

endmodule

// File: rtl/xmem_stretch.sv
// Module: xmem_stretch
// Sequences one external access: stall for (wait + 1) cycles, then one
// completing cycle with stall low. The wait count is latched at the start.
// Assumes the requester keeps the request steady while stall is high.
module xmem_stretch #(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_req,
    input  logic [WS_W-1:0] wait_cnt,
    output logic            busy,
    output logic            stall,
    output logic            last
);

    localparam logic [WS_W:0] ONE = {{WS_W{1'b0}}, 1'b1};

    logic            active_q;
    logic [WS_W:0]   cnt_q;
    logic [WS_W:0]   len_q;
    logic [WS_W:0]   len_now;

    // Purpose: number of stall cycles requested by the current setting
    always_comb begin
        len_now = {1'b0, wait_cnt} + ONE;
    end

    // Purpose: stall and last-stall-cycle flags from the sequencer state
    always_comb begin
        if (active_q) begin
            stall = (cnt_q < len_q);
            last  = (cnt_q == (len_q - ONE));
        end else begin
            stall = ext_req;
            last  = ext_req && (len_now == ONE);
        end
    end

    // Purpose: advance the cycle counter through one stretched access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            len_q    <= '0;
        end else if (!active_q) begin
            if (ext_req) begin
                active_q <= 1'b1;
                cnt_q    <= ONE;
                len_q    <= len_now;
            end
        end else if (cnt_q == len_q) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign busy = active_q;

endmodule

// File: rtl/xmem_ext_port.sv
// Module: xmem_ext_port
// Drives the external SRAM bus: address, write data and active-low strobes,
// and captures read data on the last stall cycle.
// Assumes stall is high only during an external access.
module xmem_ext_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req,
    input  logic              busy,
    input  logic              stall,
    input  logic              last,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic [DATA_W-1:0] rd_hold
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic              write_sel;

    // Purpose: latch the access on its first cycle so the bus holds steady
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (!busy && ext_req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    // Purpose: bus values come from the request on the first cycle, latch after
    always_comb begin
        if (busy) begin
            ext_addr  = addr_q;
            ext_wdata = wdata_q;
            write_sel = write_q;
        end else begin
            ext_addr  = req_addr;
            ext_wdata = req_wdata;
            write_sel = req_write;
        end
        ext_rd_n = !(stall && !write_sel);
        ext_wr_n = !(stall && write_sel);
    end

    // Purpose: capture read data in the final stall cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hold <= '0;
        end else if (stall && last && !write_sel) begin
            rd_hold <= ext_rdata;
        end
    end

endmodule

// File: rtl/xmem_access_ctrl.sv
// Module: xmem_access_ctrl (top)
// Routes CPU data accesses to the internal port or the external SRAM bus,
// stretching external accesses by the configured wait states.
// Assumes the internal memory reads combinationally and the CPU holds its
// request while cpu_stall is high.
module xmem_access_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int WS_W    = 2,
    parameter int INT_TOP = 8448
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cpu_stall,
    input  logic              cfg_ext_en,
    input  logic [WS_W-1:0]   cfg_wait,
    output logic              int_sel,
    output logic              int_write,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);

    region_e           region;
    logic              ext_req;
    logic              busy;
    logic              stall;
    logic              last;
    logic [DATA_W-1:0] rd_hold;

    xmem_decode #(
        .ADDR_W  (ADDR_W),
        .INT_TOP (INT_TOP)
    ) u_decode (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .ext_en    (cfg_ext_en),
        .region    (region)
    );

    assign ext_req = (region == RG_EXT);

    xmem_stretch #(
        .WS_W (WS_W)
    ) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_req  (ext_req),
        .wait_cnt (cfg_wait),
        .busy     (busy),
        .stall    (stall),
        .last     (last)
    );

    xmem_ext_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_req   (ext_req),
        .busy      (busy),
        .stall     (stall),
        .last      (last),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ext_rdata (ext_rdata),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .rd_hold   (rd_hold)
    );

    // Purpose: internal port is a pass-through gated by the decode
    always_comb begin
        int_sel   = (region == RG_INT);
        int_write = int_sel && req_write;
        int_addr  = req_addr;
        int_wdata = req_wdata;
    end

    // Purpose: select load data for the CPU (zero for disabled region)
    always_comb begin
        if (busy) begin
            rsp_rdata = rd_hold;
        end else if (region == RG_INT) begin
            rsp_rdata = int_rdata;
        end else begin
            rsp_rdata = '0;
        end
    end

    assign cpu_stall = stall;

endmodule

// File: rtl/xmem_access_chk.sv
// Module: xmem_access_chk
// Property checker for xmem_access_ctrl, attached with bind below.
// Assumes synchronous active-low reset; all properties disabled in reset.
module xmem_access_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WS_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_stall,
    input logic              int_sel,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [DATA_W-1:0] ext_wdata
);

    localparam logic [WS_W:0] MAX_RUN = {1'b1, {WS_W{1'b0}}};
    localparam logic [WS_W:0] ONE     = {{WS_W{1'b0}}, 1'b1};

    logic [WS_W:0] run_q;

    // Purpose: count stall cycles already seen in the current run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (cpu_stall) begin
            run_q <= run_q + ONE;
        end else begin
            run_q <= '0;
        end
    end

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    a_r3_strobe_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> cpu_stall);

    a_r1_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (ext_rd_n && ext_wr_n && !cpu_stall));

    a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |=> ($stable(ext_addr) && $stable(ext_wdata)));

    a_r2_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (run_q < MAX_RUN));

endmodule

bind xmem_access_ctrl xmem_access_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WS_W   (WS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_stall (cpu_stall),
    .int_sel   (int_sel),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata)
);

// File: tb/sim_xmem_access_ctrl.sv
// Directed bench for xmem_access_ctrl: one task per scenario.
module sim_xmem_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        cpu_stall;
    logic        cfg_ext_en = 1'b1;
    logic [1:0]  cfg_wait = '0;
    logic        int_sel;
    logic        int_write;
    logic [15:0] int_addr;
    logic [7:0]  int_wdata;
    logic [7:0]  int_rdata;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic [7:0]  ext_rdata;
    logic        ext_rd_n;
    logic        ext_wr_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] xdat(input logic [15:0] a);
        return (a[7:0] + a[15:8]) ^ 8'h3C;
    endfunction

    function automatic logic [7:0] idat(input logic [15:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // Memory models: SRAM drives garbage unless its read strobe is low
    assign int_rdata = int_sel ? idat(int_addr) : 8'h00;
    assign ext_rdata = !ext_rd_n ? xdat(ext_addr) : 8'hEE;

    xmem_access_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .cpu_stall(cpu_stall), .cfg_ext_en(cfg_ext_en), .cfg_wait(cfg_wait),
        .int_sel(int_sel), .int_write(int_write), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Drop the request for one cycle (called at a falling edge)
    task automatic idle();
        req_valid = 1'b0;
        req_write = 1'b0;
        @(negedge clk);
    endtask

    // Internal access: completes in one cycle with no stall or strobe
    task automatic int_acc(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           input string tag);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #2;
        chk(int_sel === 1'b1, {tag, " R1 int_sel"}, int_sel, 1);
        chk(cpu_stall === 1'b0, {tag, " R1 no stall"}, cpu_stall, 0);
        chk(ext_rd_n === 1'b1 && ext_wr_n === 1'b1, {tag, " R1 strobes idle"},
            {ext_rd_n, ext_wr_n}, 3);
        if (wr) begin
            chk(int_write === 1'b1 && int_wdata === d, {tag, " R7 int write"},
                {int_write, int_wdata}, {1'b1, d});
        end else begin
            chk(rsp_rdata === idat(a), {tag, " R7 int read"}, rsp_rdata, idat(a));
        end
        @(negedge clk);
    endtask

    // External access: count stall cycles and watch the bus each cycle
    task automatic ext_acc(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           input logic [1:0] ws, input bit flip, input string tag);
        int  n = 0;
        bit  strobe_ok = 1'b1;
        bit  bus_ok = 1'b1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cfg_wait = ws;
        forever begin
            #2;
            if (!cpu_stall || n > 8) break;
            n++;
            if (wr ? (ext_wr_n !== 1'b0 || ext_rd_n !== 1'b1)
                   : (ext_rd_n !== 1'b0 || ext_wr_n !== 1'b1)) strobe_ok = 1'b0;
            if (ext_addr !== a || (wr && ext_wdata !== d) || int_sel !== 1'b0)
                bus_ok = 1'b0;
            @(negedge clk);
            if (flip) cfg_wait = ~ws;
        end
        chk(n == int'(ws) + 1, {tag, " R2 stall cycles"}, n, int'(ws) + 1);
        chk(strobe_ok, {tag, " R3 strobe during stall"}, strobe_ok, 1);
        chk(bus_ok, {tag, " R4 bus stable"}, bus_ok, 1);
        chk(ext_rd_n === 1'b1 && ext_wr_n === 1'b1, {tag, " R3 strobes off at end"},
            {ext_rd_n, ext_wr_n}, 3);
        if (!wr) begin
            chk(rsp_rdata === xdat(a), {tag, " R5 read data"}, rsp_rdata, xdat(a));
        end else begin
            chk(int_write === 1'b0, {tag, " R6 no internal write"}, int_write, 0);
        end
        @(negedge clk);
        cfg_wait = ws;
    endtask

    // External region with the enable clear: zero data, no stall, no strobe
    task automatic off_acc(input bit wr, input logic [15:0] a, input logic [7:0] d);
        cfg_ext_en = 1'b0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #2;
        chk(cpu_stall === 1'b0, "R6 disabled no stall", cpu_stall, 0);
        chk(ext_rd_n === 1'b1 && ext_wr_n === 1'b1, "R6 disabled strobes idle",
            {ext_rd_n, ext_wr_n}, 3);
        chk(int_sel === 1'b0 && int_write === 1'b0, "R6 disabled internal idle",
            {int_sel, int_write}, 0);
        if (!wr) chk(rsp_rdata === 8'h00, "R6 disabled read zero", rsp_rdata, 0);
        @(negedge clk);
        cfg_ext_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(cpu_stall === 1'b0, "R3 reset stall low", cpu_stall, 0);
        chk(ext_rd_n === 1'b1 && ext_wr_n === 1'b1, "R3 reset strobes high",
            {ext_rd_n, ext_wr_n}, 3);
        @(negedge clk);

        int_acc(1'b0, 16'h0000, 8'h00, "base");
        int_acc(1'b0, 16'h20FF, 8'h00, "R9 top internal");
        int_acc(1'b1, 16'h1234, 8'h5E, "R7 store");
        idle();

        ext_acc(1'b0, 16'h2100, 8'h00, 2'd0, 1'b0, "R9 first external ws0");
        idle();
        ext_acc(1'b0, 16'h5A5A, 8'h00, 2'd1, 1'b0, "ws1");
        idle();
        ext_acc(1'b0, 16'h8000, 8'h00, 2'd2, 1'b0, "ws2");
        idle();
        ext_acc(1'b0, 16'hC3A1, 8'h00, 2'd3, 1'b0, "ws3");
        idle();
        ext_acc(1'b1, 16'hFFFF, 8'h9C, 2'd2, 1'b0, "R9 top write");
        idle();
        ext_acc(1'b1, 16'h3000, 8'h11, 2'd0, 1'b0, "write ws0");
        idle();

        ext_acc(1'b0, 16'h4444, 8'h00, 2'd3, 1'b1, "R8 wait change 3->0");
        idle();
        ext_acc(1'b0, 16'h4445, 8'h00, 2'd0, 1'b1, "R8 wait change 0->3");
        idle();

        ext_acc(1'b0, 16'h6001, 8'h00, 2'd1, 1'b0, "R10 back-to-back a");
        ext_acc(1'b1, 16'h6002, 8'h77, 2'd2, 1'b0, "R10 back-to-back b");
        ext_acc(1'b0, 16'h6003, 8'h00, 2'd0, 1'b0, "R10 back-to-back c");
        int_acc(1'b0, 16'h0042, 8'h00, "R10 internal after external");
        idle();

        off_acc(1'b0, 16'h8000, 8'h00);
        off_acc(1'b1, 16'h2100, 8'hAB);
        idle();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule